// File: doc/BRIEF.md
# Reference Time Counter with One-Shot Compare Output

A 64-bit reference time counter that advances by a fixed nanosecond step on every clock while it runs. Software reaches it through a small 32-bit register bus. A control register carries two write-only strobes, one to halt the counter and one to restart it, and a two-bit field that selects the source of the timesync output pin. While the counter is halted, software loads it one 32-bit half at a time. A rate-trim register adds or removes one extra nanosecond on every Nth tick, so the counter can track a reference that runs slightly fast or slightly slow.

A 63-bit compare register with an arm bit fires exactly once. When it is armed, the first cycle in which the low 63 bits of the counter are at or above the compare value flips an internal toggle and clears the arm bit. The pin shows that toggle only while the source field selects the compare unit. A read of the counter's low half captures the high half in a shadow register, so a following read of the high half completes a coherent 64-bit value.

Top module: `tsync_clock`

## Requirements
- R1: After reset the counter is 0 and running, the source field is 00, the compare is disarmed with a compare value of 0, the toggle is 0 and `tsync_out` is 0.
- R2: With trim off, each clock edge with the counter running adds STEP_NS (default 8) to it.
- R3: A write to CTRL (0x6908) with bit 1 set halts the counter. A write with bit 2 set restarts it. If both bits are set, the halt wins. Both bits read back as 0. A halted counter keeps its value.
- R4: Every CTRL write loads the source field from bits 17:16, and that field reads back in the same place. The halt and restart strobes have no effect on the field. A strobe write that carries the current field value leaves `tsync_out` unchanged.
- R5: While the counter is halted, a write to 0x690C replaces its low 32 bits and a write to 0x6910 replaces its high 32 bits. Writes to these addresses while the counter runs are ignored.
- R6: A read of 0x690C returns the low half of the counter and copies the high half into a shadow register. A read of 0x6910 returns that shadow. Read data appears on `bus_rdata` one clock after the read strobe and is held until the next read.
- R7: 0x6918 holds compare bits 31:0. 0x691C holds compare bits 62:32 in bits 30:0 and the arm bit in bit 31. Both registers read back what was written.
- R8: While the compare is armed, the first cycle in which counter bits 62:0 are greater than or equal to the compare value flips the toggle on the next edge and clears the arm bit in hardware. The toggle does not flip again until the compare is re-armed.
- R9: When the source field is 10, `tsync_out` shows the toggle. For any other field value, `tsync_out` is 0.
- R10: Writing 0 to 0x691C disarms the compare, and the toggle then never flips.
- R11: TRIM (0x6928) has bit 31 = enable, bit 30 = subtract, and bits 23:0 = N. With trim enabled and N nonzero, every Nth running tick counted from when trim was enabled adds STEP_NS+1, or STEP_NS−1 when subtract is set. N = 0 turns trim off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| tsync_out | output | 1 | One-shot timesync output pin |

## Verification
The assertions assume that software loads the counter halves only while the counter is halted, and that the trim step never takes a tick below STEP_NS−1 or above STEP_NS+1. The bench keeps within these assumptions: every load happens after a halt strobe, and the trim period it programs is always at least 1. For compare tests it picks counter seeds below 2^62, so adding the compare offset cannot wrap the 63-bit compare. It also arms the compare only while the counter is halted and still below the target, so the firing edge follows from the restart edge alone.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 16;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 16'h6908;
    localparam logic [ADDR_W-1:0] OFS_CNTLO = 16'h690C;
    localparam logic [ADDR_W-1:0] OFS_CNTHI = 16'h6910;
    localparam logic [ADDR_W-1:0] OFS_CMPLO = 16'h6918;
    localparam logic [ADDR_W-1:0] OFS_CMPHI = 16'h691C;
    localparam logic [ADDR_W-1:0] OFS_TRIM  = 16'h6928;

    localparam int HALT_BIT   = 1;
    localparam int GO_BIT     = 2;
    localparam int SRC_LSB    = 16;
    localparam int TRIM_EN    = 31;
    localparam int TRIM_SUB   = 30;
    localparam int TRIM_N_W   = 24;

    localparam logic [1:0] SRC_CMP0 = 2'b10;

    typedef struct packed {
        logic                run;
        logic [1:0]          src;
        logic                trim_en;
        logic                trim_sub;
        logic [TRIM_N_W-1:0] trim_n;
        logic [DATA_W-1:0]   shadow;
        logic [DATA_W-1:0]   rdata;
    } host_regs_t;
endpackage

// File: rtl/tsync_rate.sv
module tsync_rate #(
    parameter int STEP_NS = 8,
    parameter int STEP_W  = 8,
    parameter int N_W     = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              trim_en,
    input  logic              trim_sub,
    input  logic [N_W-1:0]    trim_n,
    output logic [STEP_W-1:0] step
);
    logic [N_W-1:0] tick_d, tick_q;
    logic           active, fire;

    always_comb begin
        active = trim_en && (trim_n != '0);
        fire   = active && run && (tick_q == trim_n - 1'b1);
        step   = STEP_W'(STEP_NS);
        if (fire) begin
            step = trim_sub ? step - 1'b1 : step + 1'b1;
        end
        tick_d = tick_q;
        if (!active) begin
            tick_d = '0;
        end else if (run) begin
            tick_d = fire ? '0 : tick_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_d;
    end
endmodule

// File: rtl/tsync_counter.sv
module tsync_counter #(
    parameter int CNT_W  = 64,
    parameter int STEP_W = 8,
    localparam int HALF  = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [HALF-1:0]   ld_data,
    input  logic [STEP_W-1:0] step,
    output logic [CNT_W-1:0]  cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run) begin
            cnt_d = cnt_q + CNT_W'(step);
        end else begin
            if (ld_lo) cnt_d[HALF-1:0]     = ld_data;
            if (ld_hi) cnt_d[CNT_W-1:HALF] = ld_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tsync_compare.sv
module tsync_compare #(
    parameter int CMP_W  = 63,
    parameter int DATA_W = 32,
    localparam int HI_W  = CMP_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CMP_W-1:0]  cnt,
    output logic              armed,
    output logic              match,
    output logic              tog,
    output logic [DATA_W-1:0] cmp_lo,
    output logic [HI_W-1:0]   cmp_hi
);
    typedef struct packed {
        logic              en;
        logic [HI_W-1:0]   hi;
        logic [DATA_W-1:0] lo;
        logic              tog;
    } cmp_t;

    cmp_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        match = s_q.en && (cnt >= {s_q.hi, s_q.lo});
        if (match) begin
            s_d.tog = ~s_q.tog;
            s_d.en  = 1'b0;
        end
        if (lo_wr) s_d.lo = wdata;
        if (hi_wr) begin
            s_d.en = wdata[DATA_W-1];
            s_d.hi = wdata[HI_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign armed  = s_q.en;
    assign tog    = s_q.tog;
    assign cmp_lo = s_q.lo;
    assign cmp_hi = s_q.hi;
endmodule

// File: rtl/tsync_clock.sv
module tsync_clock
    import tsync_pkg::*;
#(
    parameter int STEP_NS = 8,
    parameter int STEP_W  = 8,
    parameter int CNT_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tsync_out
);
    localparam int CMP_W = CNT_W - 1;
    localparam int HI_W  = CMP_W - DATA_W;

    host_regs_t r_d, r_q;

    logic [CNT_W-1:0]  cnt;
    logic [STEP_W-1:0] step;
    logic              ld_lo, ld_hi, cmp_lo_wr, cmp_hi_wr;
    logic              armed, match, tog;
    logic [DATA_W-1:0] cmp_lo;
    logic [HI_W-1:0]   cmp_hi;

    always_comb begin
        r_d       = r_q;
        ld_lo     = bus_we && (bus_addr == OFS_CNTLO) && !r_q.run;
        ld_hi     = bus_we && (bus_addr == OFS_CNTHI) && !r_q.run;
        cmp_lo_wr = bus_we && (bus_addr == OFS_CMPLO);
        cmp_hi_wr = bus_we && (bus_addr == OFS_CMPHI);

        if (bus_we && bus_addr == OFS_CTRL) begin
            r_d.src = bus_wdata[SRC_LSB+1:SRC_LSB];
            if (bus_wdata[GO_BIT])   r_d.run = 1'b1;
            if (bus_wdata[HALT_BIT]) r_d.run = 1'b0;
        end
        if (bus_we && bus_addr == OFS_TRIM) begin
            r_d.trim_en  = bus_wdata[TRIM_EN];
            r_d.trim_sub = bus_wdata[TRIM_SUB];
            r_d.trim_n   = bus_wdata[TRIM_N_W-1:0];
        end

        if (bus_re) begin
            r_d.rdata = '0;
            case (bus_addr)
                OFS_CTRL:  r_d.rdata[SRC_LSB+1:SRC_LSB] = r_q.src;
                OFS_CNTLO: begin
                    r_d.rdata  = cnt[DATA_W-1:0];
                    r_d.shadow = cnt[CNT_W-1:DATA_W];
                end
                OFS_CNTHI: r_d.rdata = r_q.shadow;
                OFS_CMPLO: r_d.rdata = cmp_lo;
                OFS_CMPHI: r_d.rdata = {armed, cmp_hi};
                OFS_TRIM: begin
                    r_d.rdata[TRIM_EN]        = r_q.trim_en;
                    r_d.rdata[TRIM_SUB]       = r_q.trim_sub;
                    r_d.rdata[TRIM_N_W-1:0]   = r_q.trim_n;
                end
                default:   r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.run <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    tsync_rate #(.STEP_NS(STEP_NS), .STEP_W(STEP_W), .N_W(TRIM_N_W)) i_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (r_q.run),
        .trim_en  (r_q.trim_en),
        .trim_sub (r_q.trim_sub),
        .trim_n   (r_q.trim_n),
        .step     (step)
    );

    tsync_counter #(.CNT_W(CNT_W), .STEP_W(STEP_W)) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.run),
        .ld_lo   (ld_lo),
        .ld_hi   (ld_hi),
        .ld_data (bus_wdata),
        .step    (step),
        .cnt     (cnt)
    );

    tsync_compare #(.CMP_W(CMP_W), .DATA_W(DATA_W)) i_compare (
        .clk    (clk),
        .rst_n  (rst_n),
        .lo_wr  (cmp_lo_wr),
        .hi_wr  (cmp_hi_wr),
        .wdata  (bus_wdata),
        .cnt    (cnt[CMP_W-1:0]),
        .armed  (armed),
        .match  (match),
        .tog    (tog),
        .cmp_lo (cmp_lo),
        .cmp_hi (cmp_hi)
    );

    assign bus_rdata = r_q.rdata;
    assign tsync_out = (r_q.src == SRC_CMP0) && tog;
endmodule

// File: rtl/tsync_clock_chk.sv
module tsync_clock_chk #(
    parameter int STEP_NS = 8,
    parameter int STEP_W  = 8,
    parameter int CNT_W   = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              trim_en,
    input logic              ld_any,
    input logic [CNT_W-1:0]  cnt,
    input logic [STEP_W-1:0] step,
    input logic              match,
    input logic              hi_wr,
    input logic              armed,
    input logic              tog,
    input logic [1:0]        src,
    input logic              tsync_out
);
    // R3: a halted counter with no load pending keeps its value
    p_halt_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_any) |=> (cnt == $past(cnt)));

    // R2: untrimmed running ticks add exactly the base step
    p_base_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !trim_en) |=> ((cnt - $past(cnt)) == CNT_W'(STEP_NS)));

    // R11: a trimmed step stays within one nanosecond of the base
    p_step_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ((step >= STEP_W'(STEP_NS - 1)) && (step <= STEP_W'(STEP_NS + 1))));

    // R8: a match without a concurrent re-arm leaves the compare disarmed
    p_disarm_after_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !hi_wr) |=> !armed);

    // R8: the toggle only moves out of an armed state
    p_toggle_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tog != $past(tog)) |-> $past(armed));

    // R9: any source other than the compare keeps the pin low
    p_pin_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (src != 2'b10) |-> !tsync_out);
endmodule

bind tsync_clock tsync_clock_chk #(.STEP_NS(STEP_NS), .STEP_W(STEP_W), .CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (r_q.run),
    .trim_en   (r_q.trim_en),
    .ld_any    (ld_lo || ld_hi),
    .cnt       (cnt),
    .step      (step),
    .match     (match),
    .hi_wr     (cmp_hi_wr),
    .armed     (armed),
    .tog       (tog),
    .src       (r_q.src),
    .tsync_out (tsync_out)
);

// File: tb/test_tsync_clock.sv
module test_tsync_clock;
    localparam logic [15:0] A_CTRL  = 16'h6908;
    localparam logic [15:0] A_CNTLO = 16'h690C;
    localparam logic [15:0] A_CNTHI = 16'h6910;
    localparam logic [15:0] A_CMPLO = 16'h6918;
    localparam logic [15:0] A_CMPHI = 16'h691C;
    localparam logic [15:0] A_TRIM  = 16'h6928;
    localparam longint unsigned STEP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        tsync_out;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          tog_exp = 1'b0;

    always #2 clk = ~clk;

    tsync_clock i_tsync_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .tsync_out (tsync_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd64(output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(A_CNTLO, lo);
        rd(A_CNTHI, hi);
        v = {hi, lo};
    endtask

    task automatic load(input logic [63:0] v);
        wr(A_CNTLO, v[31:0]);
        wr(A_CNTHI, v[63:32]);
    endtask

    function automatic longint unsigned ceil_step(input longint unsigned d);
        return (d + STEP - 1) / STEP;
    endfunction

    // halted; load, restart, run k idle edges, halt: k+1 running ticks
    task automatic span(input logic [63:0] start, input int k, input string req,
                        input longint unsigned n, input bit sub);
        logic [63:0] got, exp;
        longint unsigned t;
        load(start);
        wr(A_CTRL, 32'h0000_0004);
        idle(k);
        wr(A_CTRL, 32'h0000_0002);
        rd64(got);
        t = longint'(k) + 1;
        exp = start + STEP * t;
        if (n != 0) exp = sub ? exp - t / n : exp + t / n;
        check(req, got, exp);
    endtask

    // halted entry; arms at start+d, restarts, expects one flip k+1 edges later
    task automatic shot(input logic [63:0] start, input longint unsigned d);
        logic [62:0] cmp;
        logic [31:0] r;
        longint unsigned k;
        cmp = start[62:0] + d[62:0];
        wr(A_CTRL, 32'h0002_0002);
        load(start);
        wr(A_CMPLO, cmp[31:0]);
        wr(A_CMPHI, {1'b1, cmp[62:32]});
        rd(A_CMPHI, r);
        check("R7 arm readback", r, {1'b1, cmp[62:32]});
        rd(A_CMPLO, r);
        check("R7 low readback", r, cmp[31:0]);
        k = ceil_step(d);
        wr(A_CTRL, 32'h0002_0004);
        idle(int'(k));
        check("R8 no flip before target", tsync_out, tog_exp);
        idle(1);
        tog_exp = ~tog_exp;
        check("R8 flip at target", tsync_out, tog_exp);
        rd(A_CMPHI, r);
        check("R8 arm cleared", r, {1'b0, cmp[62:32]});
        idle(20);
        check("R8 no second flip", tsync_out, tog_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [63:0] v, w;
        void'($urandom(32'd715));
        idle(3);
        rst_n = 1'b1;

        // R1: counter 0 at the first edge after reset, running
        rd(A_CNTLO, r);
        check("R1 counter low", r, 32'h0);
        rd(A_CNTHI, r);
        check("R1 counter high", r, 32'h0);
        rd(A_CNTLO, r);
        check("R1 running", r, 32'd16);
        rd(A_CTRL, r);
        check("R1 source", r, 32'h0);
        rd(A_CMPHI, r);
        check("R1 compare disarmed", r, 32'h0);
        check("R1 pin", tsync_out, 1'b0);

        // R3: halt holds the value
        wr(A_CTRL, 32'h0000_0002);
        rd64(v);
        idle(10);
        rd64(w);
        check("R3 halted holds", w, v);

        // R5 + R2: load while halted, timed run
        span(64'h1234_5678_9ABC_DEF0, 9, "R2 base step", 0, 1'b0);

        // R5: loads ignored while running
        load(64'h0000_0000_0000_1000);
        wr(A_CTRL, 32'h0000_0004);
        wr(A_CNTLO, 32'hDEAD_BEEF);
        wr(A_CNTHI, 32'hCAFE_F00D);
        wr(A_CTRL, 32'h0000_0002);
        rd64(v);
        check("R5 running load ignored", v, 64'h1000 + STEP * 3);

        // R3: both strobes, halt wins
        wr(A_CTRL, 32'h0000_0004);
        wr(A_CTRL, 32'h0000_0006);
        rd64(v);
        idle(5);
        rd64(w);
        check("R3 halt wins", w, v);

        // R4: field kept across strobes, strobes read as zero
        wr(A_CTRL, 32'h0002_0004);
        wr(A_CTRL, 32'h0002_0002);
        rd(A_CTRL, r);
        check("R4 field with strobes", r, 32'h0002_0000);

        // R6: coherent read across a carry
        load(64'h0000_0007_FFFF_FF00);
        wr(A_CTRL, 32'h0002_0004);
        rd(A_CNTLO, r);
        check("R6 low half", r, 32'hFFFF_FF00);
        idle(50);
        rd(A_CNTHI, r);
        check("R6 shadow high", r, 32'h0000_0007);
        wr(A_CTRL, 32'h0002_0002);

        // R8 + R9: directed shot
        shot(64'h0000_0001_0000_0000, 100);
        wr(A_CTRL, 32'h0000_0000);
        check("R9 source off", tsync_out, 1'b0);
        wr(A_CTRL, 32'h0003_0000);
        check("R9 reserved source", tsync_out, 1'b0);
        wr(A_CTRL, 32'h0002_0000);
        check("R9 source on", tsync_out, tog_exp);
        wr(A_CTRL, 32'h0002_0002);
        check("R4 strobe keeps pin", tsync_out, tog_exp);

        // R10: disarm before the target
        load(64'h0000_0000_0000_5000);
        wr(A_CMPLO, 32'h0000_5000 + 32'd100);
        wr(A_CMPHI, 32'h8000_0000);
        wr(A_CTRL, 32'h0002_0004);
        idle(3);
        wr(A_CMPHI, 32'h0000_0000);
        idle(40);
        check("R10 disarmed no flip", tsync_out, tog_exp);
        rd(A_CMPHI, r);
        check("R10 disarm readback", r, 32'h0);
        wr(A_CTRL, 32'h0002_0002);

        // R11: trim register readback and directed trim
        wr(A_TRIM, 32'hC000_0003);
        rd(A_TRIM, r);
        check("R11 trim readback", r, 32'hC000_0003);
        span(64'h0, 29, "R11 subtract trim", 3, 1'b1);
        wr(A_TRIM, 32'h0);
        wr(A_TRIM, 32'h8000_0000);
        span(64'h100, 14, "R11 N zero", 0, 1'b0);
        wr(A_TRIM, 32'h0);

        // random spans, trim off
        for (int i = 0; i < 20; i++) begin
            span({$urandom, $urandom}, int'($urandom_range(0, 30)), "R2 random span", 0, 1'b0);
        end

        // random trimmed spans
        for (int i = 0; i < 8; i++) begin
            int unsigned n;
            bit sub;
            n = $urandom_range(1, 10);
            sub = 1'($urandom_range(0, 1));
            wr(A_TRIM, {1'b1, sub, 6'b0, 24'(n)});
            span({$urandom, $urandom}, int'($urandom_range(10, 60)), "R11 random trim",
                 longint'(n), sub);
            wr(A_TRIM, 32'h0);
        end

        // random one-shots
        for (int i = 0; i < 15; i++) begin
            logic [63:0] s;
            s = {2'b00, 30'($urandom), $urandom};
            shot(s, longint'($urandom_range(1, 200)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule